// File: doc/BRIEF.md
# Serial-to-Parallel Latched Output Controller

This block turns a slow serial bit stream into a set of parallel drive controls. A shift clock, sampled on the fast system clock, moves a serial bit into an 8-stage shift register on each of its rising edges. A transfer latch copies the register while the capture input is high and freezes while it is low. The latched word then passes through an override path before it leaves as per-output levels and output enables.

The override path has a fixed priority. The float control comes first and can release every output to high impedance. The force control comes next and can drive all outputs to one level. The sense control comes last and chooses whether each output carries its latch bit as is or inverted. The last shift stage is also brought out as a serial output, so several blocks can be chained on one data line. Shifting never depends on any of the control inputs. Every control input is active low except capture and sense, and the system that uses the block is expected to tie unused controls high, which is their inactive level.

Top module: `serpar_drive`

## Requirements
- R1: Each rising edge of `sclk_in` shifts the register by one place. `ser_in` enters stage 1 (bit 0) and bit i moves to bit i+1. The shift lands on the third system clock edge after the rising level is presented, because two synchronizer flops and the shift flop lie on the way.
- R2: `chain_out` always equals the last stage (bit WIDTH-1). After WIDTH shifts it therefore holds the first of those WIDTH bits.
- R3: The values of `capture`, `force_n`, `sense_sel` and `float_n` have no effect on shifting.
- R4: While `capture` is high, the latch loads the shift register on every system cycle, so a new register value appears in the latch one cycle after it is shifted in. While `capture` is low, the latch holds its value.
- R5: `float_n` low sets `out_oe` to all zeros (high impedance), whatever the other inputs are. `float_n` high sets `out_oe` to all ones.
- R6: `force_n` low with `sense_sel` low drives `out_level` to all ones. `force_n` low with `sense_sel` high drives `out_level` to all zeros.
- R7: With `force_n` high, `out_level[i]` equals latch bit i when `sense_sel` is high and its inverse when `sense_sel` is low.
- R8: `out_level` and `out_oe` are registered. A control change shows at the outputs one system cycle after it is applied.
- R9: Synchronous reset clears the shift register and the latch, drives `chain_out` low, and sets `out_level` and `out_oe` to zero.
- R10: A falling edge of `sclk_in`, or `sclk_in` held high for many cycles, causes no shift. Each high pulse causes exactly one shift.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_in | input | 1 | Serial data into stage 1 |
| sclk_in | input | 1 | Asynchronous shift clock, sampled on clk |
| capture | input | 1 | High: latch follows the shift register |
| force_n | input | 1 | Low: all outputs forced to one level |
| sense_sel | input | 1 | High: true data or forced low; low: inverted data or forced high |
| float_n | input | 1 | Low: all outputs high impedance |
| out_level | output | WIDTH | Registered per-output drive level |
| out_oe | output | WIDTH | Registered per-output enable, 1 = driven |
| chain_out | output | 1 | Last shift stage, used for daisy-chaining |

## Verification
The hardest condition to reach from the ports is a latch that holds a stale word while the shift register already carries a different one. The outputs show only the latch, and `chain_out` shows only one stage of the register. The stimulus gets there by loading one byte with capture high, then shifting a second byte with capture low. The outputs must keep the first byte, and opening the latch must then reveal the second. Single-edge timing is checked by sampling one cycle before and one cycle after the expected output change. A long high level on the shift clock confirms that only one shift occurs.

// File: rtl/serpar_pkg.sv
package serpar_pkg;
  typedef struct packed {
    logic force_n;
    logic sense_sel;
    logic float_n;
  } drive_ctl_t;
endpackage

// File: rtl/serpar_edge.sv
module serpar_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic rise
);
  logic [STAGES:0] pipe;

  always_ff @(posedge clk) begin
    if (rst) pipe <= '0;
    else     pipe <= {pipe[STAGES-1:0], async_in};
  end

  assign rise = pipe[STAGES-1] & ~pipe[STAGES];

  AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    rise |=> !rise); // R10
endmodule

// File: rtl/serpar_shift.sv
module serpar_shift #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step,
  input  logic             bit_in,
  output logic [WIDTH-1:0] stages
);
  always_ff @(posedge clk) begin
    if (rst)       stages <= '0;
    else if (step) stages <= {stages[WIDTH-2:0], bit_in};
  end

  AST_SHIFT_ADVANCE: assert property (@(posedge clk) disable iff (rst)
    step |=> stages == {$past(stages[WIDTH-2:0]), $past(bit_in)}); // R1
  AST_SHIFT_IDLE: assert property (@(posedge clk) disable iff (rst)
    !step |=> $stable(stages)); // R10
endmodule

// File: rtl/serpar_latch.sv
module serpar_latch #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             open_en,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)          q <= '0;
    else if (open_en) q <= d;
  end

  AST_LATCH_FOLLOW: assert property (@(posedge clk) disable iff (rst)
    open_en |=> q == $past(d)); // R4
  AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (rst)
    !open_en |=> $stable(q)); // R4
endmodule

// File: rtl/serpar_outstage.sv
module serpar_outstage
  import serpar_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  drive_ctl_t       ctl,
  input  logic [WIDTH-1:0] held,
  output logic [WIDTH-1:0] level,
  output logic [WIDTH-1:0] oe
);
  logic [WIDTH-1:0] level_nxt;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    always_comb begin
      if (!ctl.force_n) level_nxt[i] = ~ctl.sense_sel;
      else              level_nxt[i] = ctl.sense_sel ? held[i] : ~held[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      level <= '0;
      oe    <= '0;
    end else begin
      level <= level_nxt;
      oe    <= {WIDTH{ctl.float_n}};
    end
  end

  AST_FLOAT_ALL: assert property (@(posedge clk) disable iff (rst)
    !ctl.float_n |=> oe == '0); // R5
  AST_DRIVE_ALL: assert property (@(posedge clk) disable iff (rst)
    ctl.float_n |=> oe == '1); // R5
  AST_FORCE_HIGH: assert property (@(posedge clk) disable iff (rst)
    (!ctl.force_n && !ctl.sense_sel) |=> level == '1); // R6
  AST_FORCE_LOW: assert property (@(posedge clk) disable iff (rst)
    (!ctl.force_n && ctl.sense_sel) |=> level == '0); // R6
  AST_TRUE_DATA: assert property (@(posedge clk) disable iff (rst)
    (ctl.force_n && ctl.sense_sel) |=> level == $past(held)); // R7
  AST_INV_DATA: assert property (@(posedge clk) disable iff (rst)
    (ctl.force_n && !ctl.sense_sel) |=> level == ~$past(held)); // R7
endmodule

// File: rtl/serpar_drive.sv
module serpar_drive
  import serpar_pkg::*;
#(
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ser_in,
  input  logic             sclk_in,
  input  logic             capture,
  input  logic             force_n,
  input  logic             sense_sel,
  input  logic             float_n,
  output logic [WIDTH-1:0] out_level,
  output logic [WIDTH-1:0] out_oe,
  output logic             chain_out
);
  logic             step;
  logic [WIDTH-1:0] shift_q;
  logic [WIDTH-1:0] latch_q;
  drive_ctl_t       ctl;

  assign ctl = '{force_n: force_n, sense_sel: sense_sel, float_n: float_n};

  serpar_edge #(.STAGES(SYNC_STAGES)) u_edge (
    .clk(clk), .rst(rst), .async_in(sclk_in), .rise(step)
  );

  serpar_shift #(.WIDTH(WIDTH)) u_shift (
    .clk(clk), .rst(rst), .step(step), .bit_in(ser_in), .stages(shift_q)
  );

  serpar_latch #(.WIDTH(WIDTH)) u_latch (
    .clk(clk), .rst(rst), .open_en(capture), .d(shift_q), .q(latch_q)
  );

  serpar_outstage #(.WIDTH(WIDTH)) u_out (
    .clk(clk), .rst(rst), .ctl(ctl), .held(latch_q),
    .level(out_level), .oe(out_oe)
  );

  assign chain_out = shift_q[WIDTH-1];

  AST_CHAIN_LAST: assert property (@(posedge clk) disable iff (rst)
    step |=> chain_out == $past(shift_q[WIDTH-2])); // R2
  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (out_oe == '0 && out_level == '0 && !chain_out)); // R9
endmodule

// File: tb/serpar_drive_bench.sv
module serpar_drive_bench;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ser_in = 1'b0, sclk_in = 1'b0, capture = 1'b0;
  logic force_n = 1'b1, sense_sel = 1'b1, float_n = 1'b1;
  logic [W-1:0] out_level, out_oe;
  logic chain_out;

  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  serpar_drive #(.WIDTH(W)) u_serpar_drive (
    .clk(clk), .rst(rst), .ser_in(ser_in), .sclk_in(sclk_in),
    .capture(capture), .force_n(force_n), .sense_sel(sense_sel),
    .float_n(float_n), .out_level(out_level), .out_oe(out_oe),
    .chain_out(chain_out)
  );

  // {data[7:0], capture while shifting, force_n, sense_sel, float_n}
  localparam logic [11:0] VECS [8] = '{
    {8'hA5, 4'b1111}, {8'h3C, 4'b0110}, {8'hF0, 4'b1101},
    {8'h01, 4'b0100}, {8'h80, 4'b1011}, {8'h5A, 4'b0001},
    {8'hFF, 4'b1111}, {8'h00, 4'b0110}
  };

  function automatic logic [W-1:0] ref_level(logic [W-1:0] d, logic f_n, logic s);
    if (!f_n) return s ? '0 : '1;
    return s ? d : ~d;
  endfunction

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic shift_bit(logic b);
    ser_in = b; sclk_in = 1'b1;
    tick(4);
    sclk_in = 1'b0;
    tick(3);
  endtask

  task automatic load_byte(logic [W-1:0] d);
    for (int b = W - 1; b >= 0; b--) shift_bit(d[b]);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    tick(3);
    check("R9 reset level", out_level, '0);
    check("R9 reset oe", out_oe, '0);
    check("R9 reset chain", {7'd0, chain_out}, '0);
    rst = 1'b0;
    tick(1);

    for (int v = 0; v < 8; v++) begin
      logic [W-1:0] d;
      d = VECS[v][11:4];
      capture = VECS[v][3]; force_n = VECS[v][2];
      sense_sel = VECS[v][1]; float_n = VECS[v][0];
      load_byte(d);
      check("R2/R3 chain after byte", {7'd0, chain_out}, {7'd0, d[W-1]});
      capture = 1'b1; tick(3); capture = 1'b0; tick(2);
      check("R6/R7 level", out_level, ref_level(d, force_n, sense_sel));
      check("R5 oe", out_oe, {W{float_n}});
    end

    // R4 hold: shift a new byte with the latch closed
    force_n = 1'b1; sense_sel = 1'b1; float_n = 1'b1; capture = 1'b1;
    load_byte(8'hC3); tick(2);
    check("R7 true data", out_level, 8'hC3);
    capture = 1'b0;
    load_byte(8'hA5); tick(2);
    check("R4 latch holds", out_level, 8'hC3);
    check("R2 chain shows new head", {7'd0, chain_out}, 8'h01);
    capture = 1'b1; tick(3);
    check("R4 latch opens", out_level, 8'hA5);

    // R1/R4 single-edge timing: output change after 5 posedges
    ser_in = 1'b1; sclk_in = 1'b1;
    tick(4);
    check("R1 before output edge", out_level, 8'hA5);
    tick(1);
    check("R1 after output edge", out_level, 8'h4B);

    // R10 long high and falling edge give no extra shift
    tick(20);
    check("R10 held high", out_level, 8'h4B);
    sclk_in = 1'b0; tick(10);
    check("R10 falling edge", out_level, 8'h4B);

    // R8 one-cycle control latency
    sense_sel = 1'b0;
    check("R8 before edge", out_level, 8'h4B);
    tick(1);
    check("R8 after edge", out_level, 8'hB4);

    // R5 float overrides everything
    force_n = 1'b0; float_n = 1'b0; tick(1);
    check("R5 float", out_oe, '0);
    check("R6 forced high under float", out_level, '1);

    // R9 reset mid-operation clears latch and register
    rst = 1'b1; tick(2); rst = 1'b0;
    check("R9 mid reset oe", out_oe, '0);
    check("R9 mid reset chain", {7'd0, chain_out}, '0);
    force_n = 1'b1; sense_sel = 1'b1; float_n = 1'b1; capture = 1'b1;
    tick(3);
    check("R9 latch cleared", out_level, '0);
    check("R5 driven", out_oe, '1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule